// File: doc/BRIEF.md
# Synchronizer Operating Mode Controller

This block sequences the operating mode of a network timing DPLL. A two-bit mode select chooses between locked operation, frozen-frequency holdover and free-running operation from the local oscillator. While locked operation is selected, a reference-valid flag from an external monitor moves the machine between Normal and an automatic holdover state. The select pins have no say in those two moves.

The state advances only on cycles where the frame strobe enable is high. In a system this is the 8 kHz frame strobe, reduced to a single-cycle pulse. On each mode change the controller also decides the phase-offset compensation enable. Most changes switch compensation off. The two re-entries into Normal from a holdover state instead take the level of an external enable pin. The outputs are a two-bit mode code for the DPLL datapath and three one-hot status flags.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the controller is in Freerun: `dpll_mode`=2'b10, `freerun_o`=1, `tie_on`=0.
- R2: On a cycle where `frame_tick` is 0, neither the state nor `tie_on` changes, whatever the other inputs do.
- R3: On a `frame_tick` cycle with `mode_sel`=2'b10, the next state is Freerun from any state.
- R4: On a `frame_tick` cycle with `mode_sel`=2'b01, the next state is Holdover from any state.
- R5: On a `frame_tick` cycle with `mode_sel`=2'b00, Freerun and Holdover move to Normal, whatever `ref_ok` is.
- R6: On a `frame_tick` cycle with `mode_sel`=2'b00, Normal moves to Auto-Holdover when `ref_ok`=0. Auto-Holdover moves back to Normal when `ref_ok`=1. Otherwise each of them stays put.
- R7: On a `frame_tick` cycle with the reserved `mode_sel`=2'b11, the state and `tie_on` keep their values.
- R8: Any state change clears `tie_on`, except Holdover→Normal and Auto-Holdover→Normal.
- R9: On Holdover→Normal or Auto-Holdover→Normal, `tie_on` takes the value of `tie_en_in` on that tick.
- R10: When a tick leaves the state unchanged, `tie_on` keeps its value and `tie_en_in` is ignored.
- R11: Exactly one status flag is high: `normal_o` in Normal, `holdover_o` in Holdover and Auto-Holdover, `freerun_o` in Freerun.
- R12: `dpll_mode` is 2'b00 in Normal, 2'b01 in both holdover states and 2'b10 in Freerun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | Single-cycle frame strobe enable; the state advances only on these cycles |
| mode_sel | input | 2 | Mode select: 00 normal, 01 holdover, 10 freerun, 11 reserved |
| tie_en_in | input | 1 | Compensation enable, sampled on a return from holdover to Normal |
| ref_ok | input | 1 | Reference-valid flag from the reference monitor |
| dpll_mode | output | 2 | Mode code sent to the DPLL |
| tie_on | output | 1 | Phase-offset compensation enable |
| normal_o | output | 1 | High in Normal |
| holdover_o | output | 1 | High in Holdover or Auto-Holdover |
| freerun_o | output | 1 | High in Freerun |

## Verification
The bench builds the block with its only width setting at the default two-bit select and mode code, so all four select codes, the reserved one included, can be driven. Directed sequences walk every transition in the state diagram with both levels of `tie_en_in`. They include the two ways back into Normal and the automatic drop to Auto-Holdover. A long pseudo-random run with a sparse `frame_tick` then mixes idle cycles, reserved codes and `ref_ok` toggles, so that changes on non-tick cycles and compensation carried across a tick with no state change are both tried.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    ST_FREERUN  = 2'd0,
    ST_NORMAL   = 2'd1,
    ST_AUTOHOLD = 2'd2,
    ST_HOLDOVER = 2'd3
  } sync_state_t;

  // select-pin codes; the DPLL mode code reuses the same values
  localparam logic [MODE_W-1:0] SEL_NORMAL   = 2'b00;
  localparam logic [MODE_W-1:0] SEL_HOLDOVER = 2'b01;
  localparam logic [MODE_W-1:0] SEL_FREERUN  = 2'b10;
  localparam logic [MODE_W-1:0] SEL_RSVD     = 2'b11;

endpackage

// File: rtl/sync_mode_next.sv
module sync_mode_next
  import sync_mode_pkg::*;
(
  input  sync_state_t       state_q,
  input  logic              tie_q,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              ref_ok,
  input  logic              tie_en_in,
  output sync_state_t       state_d,
  output logic              tie_d
);

  logic from_hold;

  always_comb begin
    state_d = state_q;
    unique case (mode_sel)
      SEL_FREERUN:  state_d = ST_FREERUN;
      SEL_HOLDOVER: state_d = ST_HOLDOVER;
      SEL_NORMAL: begin
        unique case (state_q)
          ST_NORMAL:   state_d = ref_ok ? ST_NORMAL : ST_AUTOHOLD;
          ST_AUTOHOLD: state_d = ref_ok ? ST_NORMAL : ST_AUTOHOLD;
          default:     state_d = ST_NORMAL;
        endcase
      end
      default:      state_d = state_q;
    endcase
  end

  assign from_hold = (state_q == ST_HOLDOVER) || (state_q == ST_AUTOHOLD);

  always_comb begin
    if (state_d == state_q)
      tie_d = tie_q;
    else if (state_d == ST_NORMAL && from_hold)
      tie_d = tie_en_in;
    else
      tie_d = 1'b0;
  end

endmodule

// File: rtl/sync_mode_status.sv
module sync_mode_status
  import sync_mode_pkg::*;
(
  input  sync_state_t       state_q,
  output logic [MODE_W-1:0] dpll_mode,
  output logic              normal_o,
  output logic              holdover_o,
  output logic              freerun_o
);

  always_comb begin
    normal_o   = 1'b0;
    holdover_o = 1'b0;
    freerun_o  = 1'b0;
    dpll_mode  = SEL_FREERUN;
    unique case (state_q)
      ST_NORMAL: begin
        normal_o  = 1'b1;
        dpll_mode = SEL_NORMAL;
      end
      ST_AUTOHOLD, ST_HOLDOVER: begin
        holdover_o = 1'b1;
        dpll_mode  = SEL_HOLDOVER;
      end
      default: begin
        freerun_o = 1'b1;
        dpll_mode = SEL_FREERUN;
      end
    endcase
  end

endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
  import sync_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              tie_en_in,
  input  logic              ref_ok,
  output logic [MODE_W-1:0] dpll_mode,
  output logic              tie_on,
  output logic              normal_o,
  output logic              holdover_o,
  output logic              freerun_o
);

  sync_state_t state_q, state_d;
  logic        tie_q, tie_d;

  sync_mode_next u_next (
    .state_q   (state_q),
    .tie_q     (tie_q),
    .mode_sel  (mode_sel),
    .ref_ok    (ref_ok),
    .tie_en_in (tie_en_in),
    .state_d   (state_d),
    .tie_d     (tie_d)
  );

  // state register, advanced only by the frame strobe enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FREERUN;
      tie_q   <= 1'b0;
    end else if (frame_tick) begin
      state_q <= state_d;
      tie_q   <= tie_d;
    end
  end

  assign tie_on = tie_q;

  sync_mode_status u_status (
    .state_q    (state_q),
    .dpll_mode  (dpll_mode),
    .normal_o   (normal_o),
    .holdover_o (holdover_o),
    .freerun_o  (freerun_o)
  );

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(state_q) && $stable(tie_q))); // R2

  AST_SEL_FREERUN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && mode_sel == SEL_FREERUN) |=> freerun_o); // R3

  AST_SEL_HOLDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && mode_sel == SEL_HOLDOVER) |=> (state_q == ST_HOLDOVER)); // R4

  AST_AUTO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && mode_sel == SEL_NORMAL && state_q == ST_NORMAL && !ref_ok)
      |=> (state_q == ST_AUTOHOLD)); // R6

  AST_RSVD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && mode_sel == SEL_RSVD) |=> ($stable(state_q) && $stable(tie_q))); // R7

  AST_TIE_AUTO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && state_d != state_q &&
     !(state_d == ST_NORMAL && (state_q == ST_HOLDOVER || state_q == ST_AUTOHOLD)))
      |=> !tie_on); // R8

  AST_TIE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && state_d == ST_NORMAL &&
     (state_q == ST_HOLDOVER || state_q == ST_AUTOHOLD))
      |=> (tie_on == $past(tie_en_in))); // R9

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({normal_o, holdover_o, freerun_o})); // R11

endmodule

// File: tb/sync_mode_ctrl_test.sv
module sync_mode_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_tick;
  logic [1:0] mode_sel;
  logic       tie_en_in;
  logic       ref_ok;
  logic [1:0] dpll_mode;
  logic       tie_on, normal_o, holdover_o, freerun_o;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  // model state: 0 freerun, 1 normal, 2 auto-holdover, 3 holdover
  int m_st  = 0;
  bit m_tie = 1'b0;

  always #2 clk = ~clk;

  sync_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mode_sel(mode_sel),
    .tie_en_in(tie_en_in), .ref_ok(ref_ok), .dpll_mode(dpll_mode),
    .tie_on(tie_on), .normal_o(normal_o), .holdover_o(holdover_o),
    .freerun_o(freerun_o)
  );

  task automatic compare(input string req);
    logic [1:0] e_mode;
    logic [2:0] e_flags;
    logic [2:0] a_flags;
    e_mode  = (m_st == 1) ? 2'b00 : (m_st == 0) ? 2'b10 : 2'b01;
    e_flags = {m_st == 1, m_st >= 2, m_st == 0};
    a_flags = {normal_o, holdover_o, freerun_o};
    vectors++;
    if (dpll_mode !== e_mode || tie_on !== m_tie || a_flags !== e_flags) begin
      misses++;
      $display("FAIL %s: mode=%b tie=%b flags=%b expected mode=%b tie=%b flags=%b",
               req, dpll_mode, tie_on, a_flags, e_mode, m_tie, e_flags);
    end
  endtask

  task automatic model_tick(input bit tk, input logic [1:0] sel, input bit te, input bit rv);
    int nx;
    if (!tk) return;
    nx = m_st;
    case (sel)
      2'b10: nx = 0;
      2'b01: nx = 3;
      2'b00: if (m_st == 1 || m_st == 2) nx = rv ? 1 : 2; else nx = 1;
      default: nx = m_st;
    endcase
    if (nx != m_st) m_tie = (nx == 1 && m_st >= 2) ? te : 1'b0;
    m_st = nx;
  endtask

  // drive at negedge, advance model at posedge, compare 1 ns later
  task automatic step(input bit tk, input logic [1:0] sel, input bit te,
                      input bit rv, input string req);
    @(negedge clk);
    frame_tick = tk; mode_sel = sel; tie_en_in = te; ref_ok = rv;
    @(posedge clk);
    model_tick(tk, sel, te, rv);
    #1;
    compare(req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_tick = 1'b0; mode_sel = 2'b10; tie_en_in = 1'b1; ref_ok = 1'b1;
    repeat (3) @(posedge clk);
    #1 compare("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    step(0, 2'b10, 1, 1, "R1 after release");
    // idle cycles with live inputs: R2
    step(0, 2'b00, 1, 1, "R2 no tick");
    step(0, 2'b01, 1, 0, "R2 no tick");
    // freerun -> normal never enables compensation: R5 R8
    step(1, 2'b00, 1, 0, "R5 freerun to normal");
    // normal -> auto-holdover on invalid reference: R6
    step(1, 2'b00, 1, 0, "R6 drop to auto-holdover");
    step(1, 2'b00, 1, 0, "R6 stay auto-holdover");
    step(1, 2'b00, 1, 1, "R9 auto-holdover return tie=1");
    // normal stays, tie_en ignored: R10
    step(1, 2'b00, 0, 1, "R10 tie kept");
    // reserved code holds: R7
    step(1, 2'b11, 0, 0, "R7 reserved hold");
    // to holdover clears compensation: R4 R8
    step(1, 2'b01, 1, 1, "R4 select holdover");
    step(1, 2'b00, 0, 0, "R9 holdover return tie=0");
    step(1, 2'b01, 1, 1, "R4 select holdover");
    step(1, 2'b00, 1, 0, "R9 holdover return tie=1");
    step(1, 2'b00, 0, 0, "R6 drop with tie cleared R8");
    step(1, 2'b00, 0, 1, "R9 auto-holdover return tie=0");
    step(1, 2'b00, 1, 0, "R6 drop");
    step(1, 2'b01, 1, 0, "R4 auto-holdover to holdover");
    step(1, 2'b00, 1, 1, "R9 return tie=1");
    step(1, 2'b10, 1, 1, "R3 normal to freerun R8");
    step(1, 2'b11, 1, 1, "R7 reserved in freerun");
    step(1, 2'b01, 1, 1, "R4 freerun to holdover R12");
    step(1, 2'b10, 1, 1, "R3 holdover to freerun R11");
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] r;
      r = 4'($urandom());
      step(r[0] & r[1], 2'($urandom()), r[2], r[3] | r[1], "R11 R12 random mix");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule